// File: doc/BRIEF.md
# Zoned Bandwidth Monitor Core

The block measures how much data crosses a bus port during a repeating sampling window. A front end, which is not part of this block, delivers one pulse per transfer beat with the number of bytes in that beat. The window length is a number of ticks of a fixed 19.2 MHz reference. The reference arrives as a single-cycle strobe (`ref_tick`) in the core clock domain. At each window end the byte total is converted to coarse count units of 2^UNIT_LOG2 bytes. The three programmed thresholds then place that total in one of four zones.

Each zone has its own action byte. The action byte of the zone that the window lands in is applied to the per-zone hit counters: each counter can be incremented, cleared or left alone. When a counter reaches the repeat count programmed for its zone, the status bit of that zone is set and the counter starts again from zero. The interrupt line is raised by any status bit whose enable is set. For each zone the block also keeps the largest window count seen. Software uses that value to move the thresholds after an interrupt.

Top module: `zbw_monitor`

## Requirements
- R1: After synchronous reset, `irq` is 0 and every readable register reads 0.
- R2: While enabled, a tick counter advances on each `ref_tick`. The window ends on the tick that brings the count to the window length, or on every tick if the length is 0 or 1. Cycles without a tick never end a window.
- R3: The window count is the floor of the accumulated bytes divided by 2^UNIT_LOG2, saturating at 4095. Bytes of a beat that arrives in the cycle a window ends count toward the next window. A window that ends with no beat in its final cycle leaves the count at 0 in the following cycle.
- R4: Zone 0 is count <= low, zone 1 is low < count <= mid, zone 2 is mid < count <= high, and zone 3 is count > high. A count equal to a threshold takes the lower zone.
- R5: Action register byte k (bits 8k+7:8k) is the action of zone k. Inside it, bit 2z+1 increments hit counter z and bit 2z clears it. Clear wins over increment, and counters saturate at 255. The four 8-bit hit counters read packed, with zone z in bits 8z+7:8z.
- R6: Repeat register byte z is the repeat count of zone z. An increment that brings counter z to that count sets status bit z and leaves the counter at 0. A repeat count of 0 never sets the status bit.
- R7: `irq` equals the OR over zones of status AND irq-enable. Status bits stay set until a 1 is written to the matching bit of the irq-clear register. A set and a clear of the same bit in the same cycle leave the bit set.
- R8: Max register z holds the largest window count of any window classified into zone z. Only the clear-all command lowers it.
- R9: While the enable bit is 0, the tick counter and accumulator are held at zero, no window ends, and no status bit is set.
- R10: A write to the control-clear register with bit 0 or bit 1 set restarts the window (timer and accumulator to zero), and a window end in that same cycle is discarded. Bit 1 also zeroes all hit counters and maxima.
- R11: Register map (byte addresses):
  - 0x00 enable (bit 0)
  - 0x04 control clear (write-only)
  - 0x08 window length (24 bits)
  - 0x0C low threshold, 0x10 mid threshold, 0x14 high threshold (12 bits each)
  - 0x18 actions
  - 0x1C repeat counts
  - 0x20 status (read-only)
  - 0x24 irq enable (4 bits)
  - 0x28 irq clear (write-only)
  - 0x2C hit counters (read-only)
  - 0x30 + 4z max of zone z (read-only)

  Write-only and unmapped addresses read 0, and writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ref_tick | input | 1 | One-cycle strobe per reference-clock tick |
| beat_valid | input | 1 | A transfer beat is present this cycle |
| beat_bytes | input | BYTES_W | Byte count of the beat |
| irq | output | 1 | Interrupt request |

## Verification
A register write becomes visible on `reg_rdata` one edge after the cycle that carries it, and reads are combinational in the cycle the address is presented. A window that ends on an edge updates the hit counters, maxima and status on that edge, so `irq` can change in the same cycle a status bit is set. The bench computes the same cycle-level state in a behavioural model, compares `irq` at every falling edge, and samples read data one time unit after presenting the address on a falling edge, well away from the active edge. Phases cover ties at each threshold, sparse ticks, disabled periods, clears that collide with window ends, and saturation of both the count and the hit counters.

// File: rtl/zbw_pkg.sv
package zbw_pkg;

    localparam int NZ    = 4;
    localparam int CNT_W = 12;
    localparam int WIN_W = 24;
    localparam int HIT_W = 8;
    localparam int ACT_W = 2 * NZ;
    localparam int ZW    = $clog2(NZ);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [ZW-1:0] {
        ZONE_QUIET = 2'd0,
        ZONE_LIGHT = 2'd1,
        ZONE_BUSY  = 2'd2,
        ZONE_PEAK  = 2'd3
    } zone_e;

    typedef struct packed {
        cnt_t lo;
        cnt_t mid;
        cnt_t hi;
    } thr_t;

    typedef enum logic [7:0] {
        RA_ENABLE  = 8'h00,
        RA_CTLCLR  = 8'h04,
        RA_WINDOW  = 8'h08,
        RA_THR_LO  = 8'h0C,
        RA_THR_MID = 8'h10,
        RA_THR_HI  = 8'h14,
        RA_ACTIONS = 8'h18,
        RA_REPEAT  = 8'h1C,
        RA_STATUS  = 8'h20,
        RA_IRQEN   = 8'h24,
        RA_IRQCLR  = 8'h28,
        RA_HITS    = 8'h2C
    } reg_addr_e;

    localparam logic [3:0] MAX_PAGE = 4'h3;

    function automatic zone_e classify(input cnt_t c, input thr_t t);
        if (c <= t.lo)       return ZONE_QUIET;
        else if (c <= t.mid) return ZONE_LIGHT;
        else if (c <= t.hi)  return ZONE_BUSY;
        else                 return ZONE_PEAK;
    endfunction

endpackage

// File: rtl/zbw_window.sv
module zbw_window
    import zbw_pkg::*;
#(
    parameter int UNIT_LOG2 = 16,
    parameter int BYTES_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               restart,
    input  logic               tick,
    input  logic [WIN_W-1:0]   win_len,
    input  logic               beat_valid,
    input  logic [BYTES_W-1:0] beat_bytes,
    output logic               win_end,
    output cnt_t               win_cnt
);
    localparam int ACC_W = CNT_W + UNIT_LOG2 + 1;

    logic [WIN_W-1:0] timer;
    logic [ACC_W-1:0] acc;
    logic             len_hit;

    assign len_hit = ({1'b0, timer} + 1'b1) >= {1'b0, win_len};
    assign win_end = run && !restart && tick && len_hit;

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            timer <= '0;
        end else if (tick) begin
            timer <= len_hit ? '0 : timer + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            acc <= '0;
        end else if (win_end) begin
            acc <= beat_valid ? ACC_W'(beat_bytes) : '0;
        end else if (beat_valid && !acc[ACC_W-1]) begin
            acc <= acc + ACC_W'(beat_bytes);
        end
    end

    assign win_cnt = acc[ACC_W-1] ? '1 : acc[ACC_W-2:UNIT_LOG2];

endmodule

// File: rtl/zbw_zone_slice.sv
module zbw_zone_slice
    import zbw_pkg::*;
#(
    parameter int ZIDX = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eval,
    input  logic             clr_all,
    input  zone_e            eval_zone,
    input  cnt_t             eval_cnt,
    input  logic [ACT_W-1:0] act,
    input  logic [HIT_W-1:0] rpt,
    output logic [HIT_W-1:0] hits,
    output cnt_t             zmax,
    output logic             set_pulse
);
    logic             do_inc;
    logic             do_clr;
    logic [HIT_W-1:0] bump;
    logic             own_zone;

    assign do_inc    = act[2*ZIDX+1];
    assign do_clr    = act[2*ZIDX];
    assign bump      = (hits == '1) ? hits : hits + 1'b1;
    assign set_pulse = eval && !do_clr && do_inc && (bump == rpt);
    assign own_zone  = (eval_zone == zone_e'(ZIDX));

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            hits <= '0;
        end else if (eval) begin
            if (do_clr || set_pulse) begin
                hits <= '0;
            end else if (do_inc) begin
                hits <= bump;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            zmax <= '0;
        end else if (eval && own_zone && (eval_cnt > zmax)) begin
            zmax <= eval_cnt;
        end
    end

endmodule

// File: rtl/zbw_monitor.sv
module zbw_monitor
    import zbw_pkg::*;
#(
    parameter int UNIT_LOG2 = 16,
    parameter int BYTES_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               ref_tick,
    input  logic               beat_valid,
    input  logic [BYTES_W-1:0] beat_bytes,
    output logic               irq
);
    logic                         mon_en;
    logic [WIN_W-1:0]             win_len;
    thr_t                         thr;
    logic [NZ-1:0][ACT_W-1:0]     act_fields;
    logic [NZ-1:0][HIT_W-1:0]     rpt_fields;
    logic [NZ-1:0]                irq_en;
    logic [NZ-1:0]                irq_status;
    logic [NZ-1:0]                set_vec;
    logic [NZ-1:0]                clr_mask;
    logic [NZ-1:0][HIT_W-1:0]     hits;
    logic [NZ-1:0][CNT_W-1:0]     zmax;
    logic                         clr_win;
    logic                         clr_all;
    logic                         win_end;
    cnt_t                         win_cnt;
    zone_e                        win_zone;

    function automatic logic wr_to(input logic [7:0] a, input reg_addr_e r);
        return reg_wr && (a == r);
    endfunction

    assign clr_win  = wr_to(reg_addr, RA_CTLCLR) && (reg_wdata[1:0] != 2'b00);
    assign clr_all  = wr_to(reg_addr, RA_CTLCLR) && reg_wdata[1];
    assign clr_mask = wr_to(reg_addr, RA_IRQCLR) ? reg_wdata[NZ-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_en     <= 1'b0;
            win_len    <= '0;
            thr        <= '0;
            act_fields <= '0;
            rpt_fields <= '0;
            irq_en     <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_ENABLE:  mon_en     <= reg_wdata[0];
                RA_WINDOW:  win_len    <= reg_wdata[WIN_W-1:0];
                RA_THR_LO:  thr.lo     <= reg_wdata[CNT_W-1:0];
                RA_THR_MID: thr.mid    <= reg_wdata[CNT_W-1:0];
                RA_THR_HI:  thr.hi     <= reg_wdata[CNT_W-1:0];
                RA_ACTIONS: act_fields <= reg_wdata[NZ*ACT_W-1:0];
                RA_REPEAT:  rpt_fields <= reg_wdata[NZ*HIT_W-1:0];
                RA_IRQEN:   irq_en     <= reg_wdata[NZ-1:0];
                default: ;
            endcase
        end
    end

    zbw_window #(
        .UNIT_LOG2 (UNIT_LOG2),
        .BYTES_W   (BYTES_W)
    ) u_window (
        .clk        (clk),
        .rst        (rst),
        .run        (mon_en),
        .restart    (clr_win),
        .tick       (ref_tick),
        .win_len    (win_len),
        .beat_valid (beat_valid),
        .beat_bytes (beat_bytes),
        .win_end    (win_end),
        .win_cnt    (win_cnt)
    );

    assign win_zone = classify(win_cnt, thr);

    for (genvar z = 0; z < NZ; z++) begin : g_zone
        zbw_zone_slice #(
            .ZIDX (z)
        ) u_slice (
            .clk       (clk),
            .rst       (rst),
            .eval      (win_end),
            .clr_all   (clr_all),
            .eval_zone (win_zone),
            .eval_cnt  (win_cnt),
            .act       (act_fields[win_zone]),
            .rpt       (rpt_fields[z]),
            .hits      (hits[z]),
            .zmax      (zmax[z]),
            .set_pulse (set_vec[z])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_status <= '0;
        end else begin
            irq_status <= (irq_status & ~clr_mask) | set_vec;
        end
    end

    assign irq = |(irq_status & irq_en);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_ENABLE:  reg_rdata[0]           = mon_en;
            RA_WINDOW:  reg_rdata[WIN_W-1:0]   = win_len;
            RA_THR_LO:  reg_rdata[CNT_W-1:0]   = thr.lo;
            RA_THR_MID: reg_rdata[CNT_W-1:0]   = thr.mid;
            RA_THR_HI:  reg_rdata[CNT_W-1:0]   = thr.hi;
            RA_ACTIONS: reg_rdata              = act_fields;
            RA_REPEAT:  reg_rdata              = rpt_fields;
            RA_STATUS:  reg_rdata[NZ-1:0]      = irq_status;
            RA_IRQEN:   reg_rdata[NZ-1:0]      = irq_en;
            RA_HITS:    reg_rdata              = hits;
            default: begin
                if (reg_addr[7:4] == MAX_PAGE && reg_addr[1:0] == 2'b00) begin
                    reg_rdata[CNT_W-1:0] = zmax[reg_addr[3:2]];
                end
            end
        endcase
    end

endmodule

// File: rtl/zbw_monitor_chk.sv
module zbw_monitor_chk
    import zbw_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     run,
    input logic                     win_end,
    input logic [CNT_W-1:0]         win_cnt,
    input logic                     beat_valid,
    input logic                     clr_all,
    input logic [NZ-1:0]            status,
    input logic [NZ-1:0][CNT_W-1:0] zmax
);

    p_idle_count_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !run |=> (win_cnt == '0));

    p_restart_after_end_r3: assert property (@(posedge clk) disable iff (rst)
        (win_end && !beat_valid) |=> (win_cnt == '0));

    p_status_needs_window_r6: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> ((status & ~$past(status)) == '0));

    for (genvar z = 0; z < NZ; z++) begin : g_max
        p_max_monotonic_r8: assert property (@(posedge clk) disable iff (rst)
            !clr_all |=> (zmax[z] >= $past(zmax[z])));
    end

endmodule

bind zbw_monitor zbw_monitor_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (mon_en),
    .win_end    (win_end),
    .win_cnt    (win_cnt),
    .beat_valid (beat_valid),
    .clr_all    (clr_all),
    .status     (irq_status),
    .zmax       (zmax)
);

// File: tb/zbw_monitor_bench.sv
module zbw_monitor_bench;

    localparam int L  = 4;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          ref_tick = 1'b0;
    logic          beat_valid = 1'b0;
    logic [BW-1:0] beat_bytes = '0;
    logic          irq;

    always #4 clk = ~clk;

    zbw_monitor #(.UNIT_LOG2(L), .BYTES_W(BW)) u_zbw_monitor (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ref_tick(ref_tick),
        .beat_valid(beat_valid), .beat_bytes(beat_bytes), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int     m_en, m_win, m_lo, m_mid, m_hi, m_ie, m_st, m_timer;
    int     m_act[4], m_rpt[4], m_hits[4], m_max[4];
    longint m_acc;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_win = 0; m_lo = 0; m_mid = 0; m_hi = 0;
            m_ie = 0; m_st = 0; m_timer = 0; m_acc = 0;
            for (int i = 0; i < 4; i++) begin
                m_act[i] = 0; m_rpt[i] = 0; m_hits[i] = 0; m_max[i] = 0;
            end
        end else begin
            bit clrw, clra, fire;
            int setv, c, zn, ac, d;
            d    = reg_wdata;
            clrw = reg_wr && reg_addr == 8'h04 && reg_wdata[1:0] != 0;
            clra = reg_wr && reg_addr == 8'h04 && reg_wdata[1];
            fire = m_en != 0 && !clrw && ref_tick && (m_timer + 1 >= m_win);
            setv = 0;
            if (fire) begin
                c  = (m_acc >> L) > 4095 ? 4095 : int'(m_acc >> L);
                zn = c <= m_lo ? 0 : c <= m_mid ? 1 : c <= m_hi ? 2 : 3;
                if (c > m_max[zn]) m_max[zn] = c;
                ac = m_act[zn];
                for (int t = 0; t < 4; t++) begin
                    if ((ac >> (2*t)) & 1) m_hits[t] = 0;
                    else if ((ac >> (2*t+1)) & 1) begin
                        int n;
                        n = m_hits[t] == 255 ? 255 : m_hits[t] + 1;
                        if (n == m_rpt[t]) begin
                            m_hits[t] = 0;
                            setv |= (1 << t);
                        end else m_hits[t] = n;
                    end
                end
            end
            if (m_en == 0 || clrw) begin
                m_timer = 0; m_acc = 0;
            end else begin
                if (ref_tick) m_timer = fire ? 0 : m_timer + 1;
                if (fire) m_acc = beat_valid ? longint'(beat_bytes) : 0;
                else if (beat_valid) m_acc += beat_bytes;
            end
            if (clra) for (int i = 0; i < 4; i++) begin
                m_hits[i] = 0; m_max[i] = 0;
            end
            if (reg_wr && reg_addr == 8'h28) m_st &= ~(d & 15);
            m_st |= setv;
            if (reg_wr) case (reg_addr)
                8'h00: m_en  = d & 1;
                8'h08: m_win = d & 32'hFFFFFF;
                8'h0C: m_lo  = d & 12'hFFF;
                8'h10: m_mid = d & 12'hFFF;
                8'h14: m_hi  = d & 12'hFFF;
                8'h18: for (int i = 0; i < 4; i++) m_act[i] = (d >> (8*i)) & 255;
                8'h1C: for (int i = 0; i < 4; i++) m_rpt[i] = (d >> (8*i)) & 255;
                8'h24: m_ie  = d & 15;
                default: ;
            endcase
        end
    end

    function automatic logic [31:0] mread(input logic [7:0] a);
        case (a)
            8'h00: return m_en;
            8'h08: return m_win;
            8'h0C: return m_lo;
            8'h10: return m_mid;
            8'h14: return m_hi;
            8'h18: return {m_act[3][7:0], m_act[2][7:0], m_act[1][7:0], m_act[0][7:0]};
            8'h1C: return {m_rpt[3][7:0], m_rpt[2][7:0], m_rpt[1][7:0], m_rpt[0][7:0]};
            8'h20: return m_st;
            8'h24: return m_ie;
            8'h2C: return {m_hits[3][7:0], m_hits[2][7:0], m_hits[1][7:0], m_hits[0][7:0]};
            8'h30: return m_max[0];
            8'h34: return m_max[1];
            8'h38: return m_max[2];
            8'h3C: return m_max[3];
            default: return 0;
        endcase
    endfunction

    // stimulus for the data path
    int  tick_mode = 0;
    bit  traffic_on = 0;
    int  bmax = 31;
    int  cyc = 0;

    always @(negedge clk) begin
        cyc++;
        ref_tick   = (tick_mode == 0) ? 1'b1 : (cyc % 3 == 0);
        beat_valid = traffic_on && ($urandom_range(0, 1) == 1);
        beat_bytes = BW'($urandom_range(0, bmax));
    end

    // R7: interrupt line compared on every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit exp_irq;
            exp_irq = (m_st & m_ie) != 0;
            checks++;
            if (irq !== exp_irq) begin
                errors++;
                $display("FAIL R7 irq actual=%0b expected=%0b at cycle %0d", irq, exp_irq, cyc);
            end
        end
    end

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rchk(input logic [7:0] a, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #1;
        exp = mread(a);
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic read_state(input string tag);
        rchk(8'h20, tag);
        rchk(8'h2C, tag);
        for (int z = 0; z < 4; z++) rchk(8'h30 + 8'(4*z), tag);
    endtask

    task automatic run_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #100000000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state, R11 map
        for (int a = 0; a < 16; a++) rchk(8'(4*a), "R1");
        checks++;
        if (irq !== 1'b0) begin
            errors++;
            $display("FAIL R1 irq actual=%0b expected=0", irq);
        end

        // standard configuration
        wreg(8'h08, 4);
        wreg(8'h0C, 1);
        wreg(8'h10, 2);
        wreg(8'h14, 4);
        wreg(8'h18, 32'h95_25_09_01);
        wreg(8'h1C, 32'h02_03_02_01);
        wreg(8'h24, 4'hF);
        for (int a = 0; a < 16; a++) rchk(8'(4*a), "R11");
        wreg(8'h00, 1);
        traffic_on = 1;

        // R4 ties and R5 R6 actions with every-cycle ticks
        for (int k = 0; k < 30; k++) begin
            run_cycles(17);
            read_state("R4");
            if (k % 3 == 0) wreg(8'h28, $urandom_range(0, 15));
        end

        // R2 sparse ticks
        tick_mode = 1;
        wreg(8'h08, 3);
        for (int k = 0; k < 15; k++) begin
            run_cycles(23);
            read_state("R2");
        end
        tick_mode = 0;

        // R7 irq clears racing window ends
        wreg(8'h08, 1);
        for (int k = 0; k < 120; k++) wreg(8'h28, $urandom_range(0, 15));
        read_state("R7");

        // R9 disabled: no windows
        wreg(8'h00, 0);
        wreg(8'h28, 15);
        run_cycles(50);
        read_state("R9");
        rchk(8'h00, "R9");
        wreg(8'h00, 1);

        // R10 restart and clear-all, including collisions with window ends
        for (int k = 0; k < 10; k++) begin
            run_cycles(7);
            wreg(8'h04, 1);
            read_state("R10");
        end
        wreg(8'h04, 2);
        read_state("R10");
        rchk(8'h04, "R11");
        rchk(8'h28, "R11");

        // R8 maxima across a wider band of counts
        wreg(8'h08, 9);
        wreg(8'h14, 12);
        bmax = 60;
        for (int k = 0; k < 15; k++) begin
            run_cycles(31);
            read_state("R8");
        end

        // R3 count saturation over a long window
        wreg(8'h04, 2);
        wreg(8'h08, 5000);
        bmax = 255;
        run_cycles(5100);
        read_state("R3");
        bmax = 31;

        // R5 R6 every zone increments everything, repeat 0 never fires
        wreg(8'h28, 15);
        wreg(8'h1C, 0);
        wreg(8'h18, 32'hAA_AA_AA_AA);
        wreg(8'h08, 1);
        wreg(8'h04, 2);
        run_cycles(300);
        read_state("R5");
        rchk(8'h20, "R6");

        traffic_on = 0;
        run_cycles(5);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule